// File: doc/BRIEF.md
# Rename History Buffer with Deferred Tag Reclaim

This block keeps, in program order, one record for every instruction that the rename stage has given a fresh destination register. Each record holds the architectural register being written, the physical tag that register pointed to before the rename, and the tag that was newly handed out. The rename stage allocates a record and gets back its slot index. The execution side marks that slot complete. Records leave from the oldest end one at a time, and only once complete. When a record leaves, the tag it displaced goes back to the free pool. This is the first moment no older in-flight instruction can still read that tag.

When a branch turns out to be mispredicted, the front end names the oldest wrong-path slot. The buffer then unwinds from the youngest record back to that slot, one record per cycle. For each record it sends the old mapping to the alias table and returns the record's fresh tag to the free pool. Unwinding youngest first means that a register written several times on the wrong path ends up with the mapping it had before the oldest of those writes. New allocations are refused while the unwind runs.

Top module: `rename_history_buf`

## Requirements
- R1: After reset the buffer holds no records: `alloc_ready` is 1, `alloc_idx` is 0, and `free_valid` and `restore_valid` are 0.
- R2: Allocations take slot indices in increasing order modulo the depth (16). Once 16 records are live, `alloc_ready` is 0 until one leaves.
- R3: A record retires only from the oldest slot, only after its slot was marked complete through `done_valid`/`done_idx`, and at most one per cycle. A complete younger record never retires ahead of an incomplete older one.
- R4: A retirement pulses `free_valid` with `free_tag` equal to that record's previous tag. A tag displaced by a younger record is not released until that younger record retires.
- R5: A flush request naming a live slot starts an unwind in the following cycle. It handles one record per cycle, from the youngest down to and including the named slot. Each step asserts `restore_valid` with the record's architectural register and previous tag, and also asserts `free_valid` with the record's fresh tag.
- R6: In the cycle of a flush request and throughout the unwind, `alloc_ready` is 0 and no record retires.
- R7: After the unwind ends, the next allocation uses the slot index named by the flush.
- R8: When one architectural register was written by several unwound records, the last restore for it carries the mapping that was current before the oldest of them.
- R9: Tags are conserved: free tags, plus one mapped tag per architectural register, plus one displaced tag per live record, always add up to the pool size of 64. A tag being freed is never one the alias table still maps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Rename stage requests a record |
| alloc_arch | input | 4 | Architectural destination register |
| alloc_prev | input | 6 | Tag the destination mapped to before rename |
| alloc_new | input | 6 | Fresh tag assigned to the destination |
| alloc_ready | output | 1 | A record can be accepted this cycle |
| alloc_idx | output | 4 | Slot index the next accepted record takes |
| done_valid | input | 1 | Mark one slot complete |
| done_idx | input | 4 | Slot being marked complete |
| flush_valid | input | 1 | Misprediction unwind request |
| flush_idx | input | 4 | Oldest slot to discard |
| restore_valid | output | 1 | Alias table write during unwind |
| restore_arch | output | 4 | Register whose mapping is restored |
| restore_tag | output | 6 | Mapping written back |
| free_valid | output | 1 | A tag returns to the free pool |
| free_tag | output | 6 | The returned tag |

## Verification
The assertions assume that `flush_idx` names a live slot. They assume no flush arrives while an unwind is already running, that `done_idx` names only live slots, and that `alloc_valid` is raised only with `alloc_ready` high. The bench keeps to these rules by tracking its own model of live records and issuing the flush only when the buffer is idle. The bench takes `alloc_prev` and `alloc_new` from a model alias table and free pool. This keeps the tag traffic consistent, so the tag conservation check is meaningful.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
    localparam int unsigned RHB_ARCH_REGS = 16;
    localparam int unsigned RHB_PHYS_TAGS = 64;
    localparam int unsigned RHB_DEPTH     = 16;

    localparam int unsigned RHB_ARCH_W = $clog2(RHB_ARCH_REGS);
    localparam int unsigned RHB_TAG_W  = $clog2(RHB_PHYS_TAGS);
    localparam int unsigned RHB_IDX_W  = $clog2(RHB_DEPTH);
    localparam int unsigned RHB_PTR_W  = RHB_IDX_W + 1;

    typedef logic [RHB_ARCH_W-1:0] arch_t;
    typedef logic [RHB_TAG_W-1:0]  tag_t;
    typedef logic [RHB_IDX_W-1:0]  idx_t;
    typedef logic [RHB_PTR_W-1:0]  ptr_t;

    typedef struct packed {
        arch_t arch;
        tag_t  prev;
        tag_t  fresh;
    } rhb_rec_t;

    typedef enum logic {
        RHB_IDLE = 1'b0,
        RHB_WALK = 1'b1
    } rhb_mode_e;

    function automatic idx_t ptr_idx(input ptr_t p);
        return p[RHB_IDX_W-1:0];
    endfunction

    function automatic logic ptr_full(input ptr_t h, input ptr_t t);
        return (h[RHB_IDX_W] != t[RHB_IDX_W]) && (ptr_idx(h) == ptr_idx(t));
    endfunction
endpackage

// File: rtl/rhb_store.sv
module rhb_store
    import rhb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  idx_t     wr_idx,
    input  rhb_rec_t wr_rec,
    input  logic     done_en,
    input  idx_t     done_idx,
    input  idx_t     head_idx,
    input  idx_t     last_idx,
    output rhb_rec_t head_rec,
    output logic     head_done,
    output rhb_rec_t last_rec
);
    rhb_rec_t recs   [RHB_DEPTH];
    logic     done_q [RHB_DEPTH];

    for (genvar s = 0; s < RHB_DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == idx_t'(s)) begin
                recs[s] <= wr_rec;
            end
            if (rst) begin
                done_q[s] <= 1'b0;
            end else if (wr_en && wr_idx == idx_t'(s)) begin
                done_q[s] <= 1'b0;
            end else if (done_en && done_idx == idx_t'(s)) begin
                done_q[s] <= 1'b1;
            end
        end
    end

    assign head_rec  = recs[head_idx];
    assign head_done = done_q[head_idx];
    assign last_rec  = recs[last_idx];
endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
    import rhb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alloc_valid,
    input  logic flush_valid,
    input  idx_t flush_idx,
    input  logic head_done,
    output idx_t head_idx,
    output idx_t tail_idx,
    output idx_t last_idx,
    output logic alloc_ready,
    output logic alloc_fire,
    output logic commit_fire,
    output logic walk_fire
);
    ptr_t      head_q, tail_q, tail_m1;
    idx_t      target_q;
    rhb_mode_e mode_q;
    logic      empty, full, walk_last;

    always_comb begin
        tail_m1     = tail_q - ptr_t'(1);
        empty       = (head_q == tail_q);
        full        = ptr_full(head_q, tail_q);
        walk_fire   = (mode_q == RHB_WALK);
        walk_last   = (ptr_idx(tail_m1) == target_q);
        alloc_ready = !full && (mode_q == RHB_IDLE) && !flush_valid;
        alloc_fire  = alloc_valid && alloc_ready;
        commit_fire = (mode_q == RHB_IDLE) && !flush_valid && !empty && head_done;
        head_idx    = ptr_idx(head_q);
        tail_idx    = ptr_idx(tail_q);
        last_idx    = ptr_idx(tail_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q   <= '0;
            tail_q   <= '0;
            target_q <= '0;
            mode_q   <= RHB_IDLE;
        end else begin
            if (commit_fire) begin
                head_q <= head_q + ptr_t'(1);
            end
            unique case (mode_q)
                RHB_IDLE: begin
                    if (alloc_fire) begin
                        tail_q <= tail_q + ptr_t'(1);
                    end
                    if (flush_valid && !empty) begin
                        mode_q   <= RHB_WALK;
                        target_q <= flush_idx;
                    end
                end
                RHB_WALK: begin
                    tail_q <= tail_m1;
                    if (walk_last) begin
                        mode_q <= RHB_IDLE;
                    end
                end
                default: mode_q <= RHB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf
    import rhb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_valid,
    input  logic [RHB_ARCH_W-1:0] alloc_arch,
    input  logic [RHB_TAG_W-1:0]  alloc_prev,
    input  logic [RHB_TAG_W-1:0]  alloc_new,
    output logic                  alloc_ready,
    output logic [RHB_IDX_W-1:0]  alloc_idx,
    input  logic                  done_valid,
    input  logic [RHB_IDX_W-1:0]  done_idx,
    input  logic                  flush_valid,
    input  logic [RHB_IDX_W-1:0]  flush_idx,
    output logic                  restore_valid,
    output logic [RHB_ARCH_W-1:0] restore_arch,
    output logic [RHB_TAG_W-1:0]  restore_tag,
    output logic                  free_valid,
    output logic [RHB_TAG_W-1:0]  free_tag
);
    if (RHB_PHYS_TAGS < RHB_ARCH_REGS + RHB_DEPTH) begin : g_pool_too_small
        $error("tag pool smaller than architectural registers plus buffer depth");
    end
    if ((1 << RHB_IDX_W) != RHB_DEPTH) begin : g_depth_not_pow2
        $error("buffer depth must be a power of two");
    end

    idx_t     head_idx, tail_idx, last_idx;
    logic     alloc_fire, commit_fire, walk_fire, head_done;
    rhb_rec_t head_rec, last_rec, in_rec;

    assign in_rec = '{arch: alloc_arch, prev: alloc_prev, fresh: alloc_new};

    rhb_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .alloc_valid (alloc_valid),
        .flush_valid (flush_valid),
        .flush_idx   (flush_idx),
        .head_done   (head_done),
        .head_idx    (head_idx),
        .tail_idx    (tail_idx),
        .last_idx    (last_idx),
        .alloc_ready (alloc_ready),
        .alloc_fire  (alloc_fire),
        .commit_fire (commit_fire),
        .walk_fire   (walk_fire)
    );

    rhb_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (alloc_fire),
        .wr_idx    (tail_idx),
        .wr_rec    (in_rec),
        .done_en   (done_valid),
        .done_idx  (done_idx),
        .head_idx  (head_idx),
        .last_idx  (last_idx),
        .head_rec  (head_rec),
        .head_done (head_done),
        .last_rec  (last_rec)
    );

    always_comb begin
        alloc_idx     = tail_idx;
        restore_valid = walk_fire;
        restore_arch  = last_rec.arch;
        restore_tag   = last_rec.prev;
        free_valid    = walk_fire || commit_fire;
        free_tag      = walk_fire ? last_rec.fresh : head_rec.prev;
    end
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker
    import rhb_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  alloc_valid,
    input logic                  alloc_ready,
    input logic                  flush_valid,
    input logic                  restore_valid,
    input logic                  free_valid
);
    logic [RHB_PTR_W:0] live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else begin
            live_q <= live_q + (RHB_PTR_W+1)'(alloc_valid && alloc_ready)
                             - (RHB_PTR_W+1)'(free_valid && restore_valid)
                             - (RHB_PTR_W+1)'(free_valid && !restore_valid);
        end
    end

    p_cap_r2: assert property (@(posedge clk) disable iff (rst)
        live_q <= (RHB_PTR_W+1)'(RHB_DEPTH));

    p_full_block_r2: assert property (@(posedge clk) disable iff (rst)
        live_q == (RHB_PTR_W+1)'(RHB_DEPTH) |-> !alloc_ready);

    p_idle_ready_r1: assert property (@(posedge clk) disable iff (rst)
        (live_q == '0) && !restore_valid && !flush_valid |-> alloc_ready);

    p_free_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        free_valid |-> live_q != '0);

    p_flush_stall_r6: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> !alloc_ready && !free_valid);

    p_walk_stall_r6: assert property (@(posedge clk) disable iff (rst)
        restore_valid |-> !alloc_ready);

    p_walk_frees_r5: assert property (@(posedge clk) disable iff (rst)
        restore_valid |-> free_valid);

    p_walk_start_r5: assert property (@(posedge clk) disable iff (rst)
        flush_valid && !restore_valid && (live_q != '0) |=> restore_valid);
endmodule

bind rename_history_buf rhb_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .alloc_valid   (alloc_valid),
    .alloc_ready   (alloc_ready),
    .flush_valid   (flush_valid),
    .restore_valid (restore_valid),
    .free_valid    (free_valid)
);

// File: tb/rename_history_buf_tb.sv
`timescale 1ns/1ps
module rename_history_buf_tb;
    import rhb_pkg::*;

    localparam int NA = RHB_ARCH_REGS;
    localparam int NP = RHB_PHYS_TAGS;
    localparam int ND = RHB_DEPTH;

    typedef struct {
        int arch;
        int prev;
        int fresh;
        int idx;
        bit done;
    } rec_m;

    logic clk = 0, rst = 1;
    logic alloc_valid = 0, done_valid = 0, flush_valid = 0;
    logic [RHB_ARCH_W-1:0] alloc_arch = '0;
    logic [RHB_TAG_W-1:0]  alloc_prev = '0, alloc_new = '0;
    logic [RHB_IDX_W-1:0]  done_idx = '0, flush_idx = '0;
    logic alloc_ready, restore_valid, free_valid;
    logic [RHB_IDX_W-1:0]  alloc_idx;
    logic [RHB_ARCH_W-1:0] restore_arch;
    logic [RHB_TAG_W-1:0]  restore_tag, free_tag;

    always #2 clk = ~clk;

    rename_history_buf u_dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_arch(alloc_arch),
        .alloc_prev(alloc_prev), .alloc_new(alloc_new),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .done_valid(done_valid), .done_idx(done_idx),
        .flush_valid(flush_valid), .flush_idx(flush_idx),
        .restore_valid(restore_valid), .restore_arch(restore_arch),
        .restore_tag(restore_tag),
        .free_valid(free_valid), .free_tag(free_tag)
    );

    int   n_checks = 0, n_errors = 0;
    int   n_commit = 0, n_restore = 0;
    int   rat [NA];
    int   snap [NA];
    int   freeq [$];
    rec_m rob_q [$];
    int   tail_m = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit in_free(input int t);
        foreach (freeq[i]) if (freeq[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit in_rat(input int t);
        foreach (rat[i]) if (rat[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    // Monitor: scoreboard pops expected records as the DUT retires or unwinds them.
    always @(negedge clk) begin
        if (!rst) begin
            if (restore_valid) begin
                rec_m r;
                n_restore++;
                chk(rob_q.size() > 0, "R5", "restore with no live record", rob_q.size(), 1);
                if (rob_q.size() > 0) begin
                    r = rob_q.pop_back();
                    chk(int'(restore_arch) == r.arch, "R5", "restore arch", restore_arch, r.arch);
                    chk(int'(restore_tag) == r.prev, "R5", "restore tag", restore_tag, r.prev);
                    chk(free_valid && int'(free_tag) == r.fresh, "R5", "unwind freed tag", free_tag, r.fresh);
                    chk(!alloc_ready, "R6", "alloc_ready during unwind", alloc_ready, 0);
                    rat[r.arch] = r.prev;
                    chk(!in_rat(r.fresh), "R9", "freed tag still mapped", r.fresh, -1);
                    freeq.push_back(r.fresh);
                    chk(freeq.size() + NA + rob_q.size() == NP, "R9", "tag count",
                        freeq.size() + NA + rob_q.size(), NP);
                end
            end else if (free_valid) begin
                rec_m r;
                n_commit++;
                chk(rob_q.size() > 0, "R3", "retire with no live record", rob_q.size(), 1);
                if (rob_q.size() > 0) begin
                    r = rob_q.pop_front();
                    chk(r.done, "R3", "retired record marked complete", r.done, 1);
                    chk(int'(free_tag) == r.prev, "R4", "retire freed tag", free_tag, r.prev);
                    chk(!in_rat(r.prev), "R9", "freed tag still mapped", r.prev, -1);
                    freeq.push_back(r.prev);
                    chk(freeq.size() + NA + rob_q.size() == NP, "R9", "tag count",
                        freeq.size() + NA + rob_q.size(), NP);
                end
            end
        end
    end

    // Driver tasks: push expected records into the model as stimulus is applied.
    task automatic do_alloc(input int arch);
        rec_m r;
        @(posedge clk); #1;
        chk(alloc_ready, "R2", "alloc_ready before allocation", alloc_ready, 1);
        chk(int'(alloc_idx) == tail_m, "R2", "allocation index", alloc_idx, tail_m);
        r.arch  = arch;
        r.prev  = rat[arch];
        r.fresh = freeq.pop_front();
        r.idx   = tail_m;
        r.done  = 1'b0;
        alloc_valid = 1; alloc_arch = arch[RHB_ARCH_W-1:0];
        alloc_prev = r.prev[RHB_TAG_W-1:0]; alloc_new = r.fresh[RHB_TAG_W-1:0];
        rob_q.push_back(r);
        rat[arch] = r.fresh;
        tail_m = (tail_m + 1) % ND;
        @(posedge clk); #1;
        alloc_valid = 0;
    endtask

    task automatic do_done(input int idx);
        @(posedge clk); #1;
        foreach (rob_q[i]) if (rob_q[i].idx == idx) rob_q[i].done = 1'b1;
        done_valid = 1; done_idx = idx[RHB_IDX_W-1:0];
        @(posedge clk); #1;
        done_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int flush_pt = 0;
        int base;
        foreach (rat[i]) rat[i] = i;
        for (int t = NA; t < NP; t++) freeq.push_back(t);
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(alloc_ready, "R1", "alloc_ready after reset", alloc_ready, 1);
        chk(alloc_idx == 0, "R1", "alloc_idx after reset", alloc_idx, 0);
        chk(!free_valid && !restore_valid, "R1", "idle outputs after reset",
            free_valid + restore_valid, 0);

        // Worked program: r1 <- ..; r4 <- r1; r1 <- ..; r8 <- r1
        do_alloc(1); do_alloc(4); do_alloc(1); do_alloc(8);
        do_done(2);
        idle(4);
        chk(n_commit == 0, "R3", "younger complete record must not retire", n_commit, 0);
        do_done(0);
        idle(4);
        chk(n_commit == 1, "R3", "only the complete head retires", n_commit, 1);
        chk(!in_free(NA), "R4", "tag displaced by slot 2 held while slot 1 live", in_free(NA), 0);
        do_done(1);
        idle(4);
        chk(n_commit == 3, "R3", "head and next complete retire in order", n_commit, 3);
        chk(in_free(NA), "R4", "displaced tag released after displacer retires", in_free(NA), 1);
        do_done(3);
        idle(4);
        chk(n_commit == 4, "R3", "last worked record retires", n_commit, 4);

        // Fill to capacity with repeated writers
        base = tail_m;
        for (int k = 0; k < ND; k++) begin
            if (k == 10) begin
                foreach (rat[i]) snap[i] = rat[i];
                flush_pt = tail_m;
            end
            do_alloc(k % 4);
        end
        chk(!alloc_ready, "R2", "alloc_ready at capacity", alloc_ready, 0);
        chk(int'(alloc_idx) == base, "R2", "index wrapped to oldest slot", alloc_idx, base);
        do_done(base);
        idle(3);
        chk(n_commit == 5, "R3", "one retirement from full buffer", n_commit, 5);
        chk(alloc_ready, "R2", "alloc_ready after a slot frees", alloc_ready, 1);
        do_alloc(3);

        // Flush back to record k=10 (7 records unwind)
        @(posedge clk); #1;
        flush_valid = 1; flush_idx = flush_pt[RHB_IDX_W-1:0];
        #0.5;
        chk(!alloc_ready, "R6", "alloc_ready in flush cycle", alloc_ready, 0);
        @(posedge clk); #1;
        flush_valid = 0;
        for (int w = 0; w < 40 && !alloc_ready; w++) begin
            @(posedge clk); #1;
        end
        chk(n_restore == 7, "R5", "records unwound", n_restore, 7);
        chk(n_commit == 5, "R6", "no retirement during unwind", n_commit, 5);
        chk(int'(alloc_idx) == flush_pt, "R7", "next index after unwind", alloc_idx, flush_pt);
        for (int a = 0; a < NA; a++)
            chk(rat[a] == snap[a], "R8", $sformatf("alias entry %0d after unwind", a), rat[a], snap[a]);
        tail_m = flush_pt;

        // Drain the survivors, marking oldest last
        for (int k = 9; k >= 1; k--) do_done((base + k) % ND);
        idle(12);
        chk(n_commit == 14, "R3", "burst retirement after head completes", n_commit, 14);
        chk(rob_q.size() == 0, "R9", "model empty after drain", rob_q.size(), 0);
        chk(freeq.size() == NP - NA, "R9", "free pool restored", freeq.size(), NP - NA);
        chk(alloc_ready, "R2", "alloc_ready when drained", alloc_ready, 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule